// File: doc/BRIEF.md
# Security Level Access Gate

This block keeps a software-controlled protection level and rules on every command that a programming front end wants to run against on-chip memory or configuration bytes. Each command arrives as a class code, with a requested level when the command changes the protection. One clock later the block answers with an allow flag and a one-byte ASCII status that the front end can send straight back to a host.

The level can only move toward stronger protection. The only way back to the open level is a full erase, which is always carried out. The level comes out of reset at a parameter value, by default the open level; it is not kept across power cycles. The current level is also driven on an output port, so the front end can report it.

Top module: `sec_gate`

## Requirements
- R1: After reset, `level` is 8'hFF (open) and `rsp_valid` is 0.
- R2: A command accepted on `cmd_valid` gives exactly one `rsp_valid` pulse on the next cycle, with no pulse in a cycle that follows an idle cycle. `status` is 8'h2E ('.') when `allow` is 1, and it is 8'h50 ('P') or 8'h4C ('L') when a command is refused.
- R3: The `cmd_class` codes are 0 memory write, 1 memory read, 2 configuration write, 3 configuration read, 4 identification read, 5 block erase or blank check, 6 full erase, and 7 level write. At level 8'hFF every class except the level write is allowed.
- R4: At level 8'hFE (write-protect), a memory write or a configuration write is refused with 'P'. A memory read, a configuration read and a block erase are still allowed.
- R5: At level 8'hFC (read and write protect), a memory read or a configuration read is refused with 'L'. A memory write, a configuration write and a block erase are refused with 'P'.
- R6: An identification read is allowed at every level.
- R7: A level write is accepted only when it raises the protection: 8'hFF to 8'hFE, 8'hFF to 8'hFC, or 8'hFE to 8'hFC. The new level shows on `level` in the same cycle as the response.
- R8: A level write that asks for the current level, a weaker level, or a value other than 8'hFE or 8'hFC is refused with 'P', and `level` does not change.
- R9: A full erase is allowed at every level and sets `level` to 8'hFF.
- R10: `level` never moves toward weaker protection, except through a full erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_class | input | 3 | Command class code |
| new_level | input | 8 | Requested level for a level write |
| rsp_valid | output | 1 | Verdict valid, one cycle after the command |
| allow | output | 1 | Command may run |
| status | output | 8 | ASCII status: '.', 'P' or 'L' |
| level | output | 8 | Current protection level |

## Verification
Every verdict (`rsp_valid`, `allow`, `status`) is due on the cycle after its command. Any level change caused by that command shows on `level` in that same cycle. The driver presents commands on falling edges and queues the expected verdict and level. The monitor samples on the next falling edge, so each comparison falls exactly one rising edge after the stimulus. Back-to-back commands and idle gaps are both exercised, and the gaps confirm that no stray response pulse appears.

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter logic [7:0] RESET_LEVEL = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_class,
  input  logic [7:0] new_level,
  output logic       rsp_valid,
  output logic       allow,
  output logic [7:0] status,
  output logic [7:0] level
);
  localparam logic [7:0] LVL_OPEN = 8'hFF;
  localparam logic [7:0] LVL_WP   = 8'hFE;
  localparam logic [7:0] LVL_RWP  = 8'hFC;
  localparam logic [7:0] ST_OK    = 8'h2E;
  localparam logic [7:0] ST_WR    = 8'h50;
  localparam logic [7:0] ST_RD    = 8'h4C;

  logic       wr_locked, rd_locked, raise_ok, ok;
  logic [7:0] deny_code;

  assign wr_locked = (level != LVL_OPEN);
  assign rd_locked = (level == LVL_RWP);
  assign raise_ok  = (new_level == LVL_WP  && level == LVL_OPEN) ||
                     (new_level == LVL_RWP && level != LVL_RWP);

  always_comb begin
    ok        = 1'b1;
    deny_code = ST_WR;
    case (cmd_class)
      3'd0, 3'd2: ok = !wr_locked;
      3'd1, 3'd3: begin ok = !rd_locked; deny_code = ST_RD; end
      3'd5:       ok = !rd_locked;
      3'd7:       ok = raise_ok;
      default:    ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      allow     <= 1'b0;
      status    <= 8'h00;
      level     <= RESET_LEVEL;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        allow  <= ok;
        status <= ok ? ST_OK : deny_code;
        if (cmd_class == 3'd6)
          level <= LVL_OPEN;
        else if (cmd_class == 3'd7 && ok)
          level <= new_level;
      end
    end
  end
endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_class,
  input logic       rsp_valid,
  input logic       allow,
  input logic [7:0] status,
  input logic [7:0] level
);
  // R2
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R2
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  // R2
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (allow ? status == 8'h2E : (status == 8'h50 || status == 8'h4C)));

  // R6
  id_read_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd4) |=> allow);

  // R9
  full_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd6) |=> (allow && level == 8'hFF));

  // R10
  level_ratchet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_class == 3'd6) |=> level <= $past(level));

  // R7
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == 8'hFF || level == 8'hFE || level == 8'hFC);
endmodule

bind sec_gate sec_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
  .rsp_valid(rsp_valid), .allow(allow), .status(status), .level(level)
);

// File: tb/test_sec_gate.sv
module test_sec_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic [7:0] new_level = 8'h00;
  logic       rsp_valid, allow;
  logic [7:0] status, level;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  bit     q_allow[$];
  byte    q_status[$];
  byte    q_level[$];
  string  q_tag[$];
  logic [7:0] model_level;

  always #4 clk = ~clk;

  sec_gate i_sec_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .new_level(new_level), .rsp_valid(rsp_valid), .allow(allow),
    .status(status), .level(level)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [2:0] cls, input logic [7:0] nl);
    bit a;
    byte s;
    a = 1'b1;
    s = 8'h2E;
    case (model_level)
      8'hFF: if (cls == 3'd7) a = (nl == 8'hFE || nl == 8'hFC);
      8'hFE: begin
        if (cls == 3'd0 || cls == 3'd2) a = 1'b0;
        if (cls == 3'd7) a = (nl == 8'hFC);
      end
      default: begin
        if (cls inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7}) a = 1'b0;
      end
    endcase
    if (!a) s = (cls == 3'd1 || cls == 3'd3) ? 8'h4C : 8'h50;
    if (cls == 3'd6) model_level = 8'hFF;
    else if (cls == 3'd7 && a) model_level = nl;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_class = cls;
    new_level = nl;
    q_allow.push_back(a);
    q_status.push_back(s);
    q_level.push_back(model_level);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_tag.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R2: actual unexpected response expected none");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " allow"}, {7'd0, allow}, {7'd0, q_allow.pop_front()});
        check({t, " status"}, status, q_status.pop_front());
        check({t, " level"}, level, q_level.pop_front());
      end
    end
  end

  initial begin
    model_level = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R1 level", level, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 open level, back-to-back
    issue("R3 mem_wr", 3'd0, 8'h00);
    issue("R3 mem_rd", 3'd1, 8'h00);
    issue("R3 cfg_wr", 3'd2, 8'h00);
    issue("R3 cfg_rd", 3'd3, 8'h00);
    issue("R3 blk_erase", 3'd5, 8'h00);
    idle(2);
    check("R2 idle no pulse", {7'd0, rsp_valid}, 8'h00);
    issue("R8 same level", 3'd7, 8'hFF);
    issue("R8 bad value", 3'd7, 8'h12);
    issue("R7 open to wp", 3'd7, 8'hFE);
    issue("R4 mem_wr", 3'd0, 8'h00);
    issue("R4 cfg_wr", 3'd2, 8'h00);
    issue("R4 mem_rd", 3'd1, 8'h00);
    issue("R4 cfg_rd", 3'd3, 8'h00);
    issue("R4 blk_erase", 3'd5, 8'h00);
    issue("R8 wp again", 3'd7, 8'hFE);
    issue("R10 lower to open", 3'd7, 8'hFF);
    issue("R6 id at wp", 3'd4, 8'h00);
    issue("R9 erase from wp", 3'd6, 8'h00);
    idle(1);
    issue("R7 open to rwp", 3'd7, 8'hFC);
    issue("R5 mem_rd", 3'd1, 8'h00);
    issue("R5 cfg_rd", 3'd3, 8'h00);
    issue("R5 mem_wr", 3'd0, 8'h00);
    issue("R5 cfg_wr", 3'd2, 8'h00);
    issue("R5 blk_erase", 3'd5, 8'h00);
    issue("R6 id at rwp", 3'd4, 8'h00);
    issue("R8 lower to wp", 3'd7, 8'hFE);
    issue("R8 rwp again", 3'd7, 8'hFC);
    issue("R9 erase from rwp", 3'd6, 8'h00);
    issue("R6 id at open", 3'd4, 8'h00);
    issue("R7 open to wp", 3'd7, 8'hFE);
    issue("R7 wp to rwp", 3'd7, 8'hFC);
    issue("R9 erase again", 3'd6, 8'h00);
    idle(3);
    check("R2 queue drained", 8'(q_tag.size()), 8'h00);
    check("R2 final idle", {7'd0, rsp_valid}, 8'h00);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule